// File: doc/BRIEF.md
# Event Timer Global Counter and Control

This block is the shared part of a multi-channel event timer. It keeps a 64-bit main counter that advances by one on each tick-enable pulse while the timer is globally enabled, and it exposes an identification/capability word, a global configuration word and the counter through a 32-bit register port. The per-channel compare logic sits outside; this block decodes the per-channel register window for it, returns that channel's read word, and tells the channels when to arm and disarm.

Clearing the global enable freezes the counter at its current value and pulses a disarm strobe to every channel. Setting it again lets the counter carry on from the frozen value and pulses an arm strobe only to channels whose comparator is not at its all-ones idle value. A legacy routing bit forces channels 0 and 1 onto fixed interrupt line numbers and drives an output that tells the older interval timer to stand down. Every other channel, and channels 0 and 1 without the legacy bit, take their line number from the route field of their own configuration word.

Top module: `evt_timer_core`

## Requirements
- R1: Byte offset 0x000 reads the capability word 0x8086A201 (bits 12:8 hold the channel count minus one, bit 13 marks a 64-bit counter, bit 15 marks legacy routing support) and offset 0x004 reads the tick period in femtoseconds (default 10,000,000); writes to either offset change nothing.
- R2: Offset 0x010 is the global configuration: bit 0 is enable and bit 1 is legacy routing, only these two bits are stored, all other bits read zero, and offset 0x014 always reads zero.
- R3: While enable is 1 (as stored before the cycle), the counter increases by exactly one per cycle with `tick_en` high, carrying from bit 31 into bit 32; while enable is 0 it holds.
- R4: A write to offset 0x0F0 replaces counter bits 31:0 and a write to 0x0F4 replaces bits 63:32, the other half keeping its value; in a cycle with such a write no increment is applied.
- R5: A write that changes enable from 1 to 0 raises `chan_disarm` for exactly the one cycle after the write, and the counter then holds.
- R6: A write that changes enable from 0 to 1 raises `chan_arm[i]` for exactly the one cycle after the write for each channel i whose `cmp_all_ones[i]` was 0 in the write cycle; the counter resumes from the held value.
- R7: With legacy routing set, channel 0's line is 0 and channel 1's line is 8; otherwise, and always for channel 2, each channel's line equals its `chan_route` field.
- R8: `legacy_timer_off` is set when the legacy bit is written from 0 to 1, cleared when it is written from 1 to 0, and cleared by reset.
- R9: An offset in 0x100..0x3FF with (offset-0x100)/0x20 below 3 sets exactly the matching bit of `chan_sel`, presents offset bits 4:0 on `chan_reg_off`, and reads that channel's `chan_rdata` word (channel i at bits 32i+31:32i); higher indices select nothing and read zero.
- R10: The status offset 0x020 and undecoded offsets read zero, and writes to them change no state.
- R11: After reset the counter, the configuration, `chan_arm`, `chan_disarm` and `legacy_timer_off` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Counter advance pulse |
| acc_wr | input | 1 | Write strobe for the register port |
| acc_addr | input | 10 | Byte offset of the access |
| acc_wdata | input | 32 | Write data |
| acc_rdata | output | 32 | Read data for `acc_addr` (combinational) |
| chan_rdata | input | 96 | Read words supplied by the three channels |
| cmp_all_ones | input | 3 | Per channel: comparator holds all ones |
| chan_route | input | 15 | Per channel 5-bit route field |
| chan_sel | output | 3 | One-hot channel window select |
| chan_reg_off | output | 5 | Register offset inside the channel window |
| chan_line | output | 15 | Per channel 5-bit interrupt line number |
| chan_arm | output | 3 | Per channel arm strobe |
| chan_disarm | output | 1 | Disarm strobe for all channels |
| main_count | output | 64 | Main counter value |
| count_enabled | output | 1 | Global enable |
| legacy_timer_off | output | 1 | Stand-down request for the older interval timer |

## Verification
The two functions that can land in one cycle are the counter increment and a write to one counter half, and also an increment with an enable write. The bench raises `tick_en` in the same cycle as a write to the low counter half and expects the written low word with an unchanged high word and no increment; it also toggles enable with `tick_en` high and expects the increment to follow the enable value held before the write. Sweeps over all arm masks, all route values with legacy on and off, and every word of the channel window complete the picture.

// File: rtl/evt_timer_pkg.sv
package evt_timer_pkg;
    localparam int ADDR_W   = 10;
    localparam int DATA_W   = 32;
    localparam int CNT_W    = 64;
    localparam int WIN_LOG2 = 5;

    localparam logic [ADDR_W-1:0] OFS_CAP_LO = 10'h000;
    localparam logic [ADDR_W-1:0] OFS_CAP_HI = 10'h004;
    localparam logic [ADDR_W-1:0] OFS_CFG    = 10'h010;
    localparam logic [ADDR_W-1:0] OFS_CNT_LO = 10'h0F0;
    localparam logic [ADDR_W-1:0] OFS_CNT_HI = 10'h0F4;
    localparam logic [ADDR_W-1:0] OFS_WIN    = 10'h100;

    typedef enum logic [2:0] {
        RS_NONE,
        RS_CAP_LO,
        RS_CAP_HI,
        RS_CFG,
        RS_CNT_LO,
        RS_CNT_HI,
        RS_CHAN
    } reg_sel_e;
endpackage

// File: rtl/evt_addr_decode.sv
module evt_addr_decode
    import evt_timer_pkg::*;
#(
    parameter int NCH   = 3,
    parameter int IDX_W = 2
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_e          reg_sel,
    output logic [NCH-1:0]    chan_sel,
    output logic [IDX_W-1:0]  chan_idx
);
    localparam int WIN_IDX_W = ADDR_W - WIN_LOG2;

    logic [ADDR_W-1:0]    win_ofs;
    logic [WIN_IDX_W-1:0] win_idx;

    assign win_ofs = addr - OFS_WIN;
    assign win_idx = win_ofs[ADDR_W-1:WIN_LOG2];

    always_comb begin
        chan_sel = '0;
        chan_idx = '0;
        case (addr)
            OFS_CAP_LO: reg_sel = RS_CAP_LO;
            OFS_CAP_HI: reg_sel = RS_CAP_HI;
            OFS_CFG:    reg_sel = RS_CFG;
            OFS_CNT_LO: reg_sel = RS_CNT_LO;
            OFS_CNT_HI: reg_sel = RS_CNT_HI;
            default:    reg_sel = RS_NONE;
        endcase
        if (addr >= OFS_WIN && int'(win_idx) < NCH) begin
            reg_sel  = RS_CHAN;
            chan_idx = win_idx[IDX_W-1:0];
            for (int i = 0; i < NCH; i++) begin
                chan_sel[i] = (int'(win_idx) == i);
            end
        end
    end
endmodule

// File: rtl/evt_route_map.sv
module evt_route_map #(
    parameter int NCH     = 3,
    parameter int ROUTE_W = 5,
    parameter int LINE_A  = 0,
    parameter int LINE_B  = 8
) (
    input  logic                   legacy,
    input  logic [NCH*ROUTE_W-1:0] route_in,
    output logic [NCH*ROUTE_W-1:0] line_out
);
    localparam logic [ROUTE_W-1:0] FIX_A = ROUTE_W'(LINE_A);
    localparam logic [ROUTE_W-1:0] FIX_B = ROUTE_W'(LINE_B);

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        if (i == 0) begin : g_fix_a
            assign line_out[i*ROUTE_W +: ROUTE_W] =
                legacy ? FIX_A : route_in[i*ROUTE_W +: ROUTE_W];
        end else if (i == 1) begin : g_fix_b
            assign line_out[i*ROUTE_W +: ROUTE_W] =
                legacy ? FIX_B : route_in[i*ROUTE_W +: ROUTE_W];
        end else begin : g_free
            assign line_out[i*ROUTE_W +: ROUTE_W] = route_in[i*ROUTE_W +: ROUTE_W];
        end
    end
endmodule

// File: rtl/evt_timer_core.sv
module evt_timer_core
    import evt_timer_pkg::*;
#(
    parameter int          NCH       = 3,
    parameter int          ROUTE_W   = 5,
    parameter logic [31:0] PERIOD_FS = 32'd10000000,
    parameter logic [15:0] VENDOR    = 16'h8086,
    parameter logic [7:0]  REVISION  = 8'h01,
    parameter int          LINE_A    = 0,
    parameter int          LINE_B    = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   tick_en,
    input  logic                   acc_wr,
    input  logic [ADDR_W-1:0]      acc_addr,
    input  logic [DATA_W-1:0]      acc_wdata,
    output logic [DATA_W-1:0]      acc_rdata,
    input  logic [NCH*DATA_W-1:0]  chan_rdata,
    input  logic [NCH-1:0]         cmp_all_ones,
    input  logic [NCH*ROUTE_W-1:0] chan_route,
    output logic [NCH-1:0]         chan_sel,
    output logic [WIN_LOG2-1:0]    chan_reg_off,
    output logic [NCH*ROUTE_W-1:0] chan_line,
    output logic [NCH-1:0]         chan_arm,
    output logic                   chan_disarm,
    output logic [CNT_W-1:0]       main_count,
    output logic                   count_enabled,
    output logic                   legacy_timer_off
);
    localparam int IDX_W = (NCH > 1) ? $clog2(NCH) : 1;
    localparam logic [4:0]  NCH_M1 = 5'(NCH - 1);
    localparam logic [31:0] CAP_LO = {VENDOR, 1'b1, 1'b0, 1'b1, NCH_M1, REVISION};

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             en;
        logic             leg;
        logic [NCH-1:0]   arm;
        logic             disarm;
    } core_state_t;

    core_state_t      st_d, st_q;
    reg_sel_e         reg_sel;
    logic [IDX_W-1:0] chan_idx;
    logic             wr_cnt_lo, wr_cnt_hi, wr_cfg, wr_cnt_any;

    evt_addr_decode #(.NCH(NCH), .IDX_W(IDX_W)) u_dec (
        .addr     (acc_addr),
        .reg_sel  (reg_sel),
        .chan_sel (chan_sel),
        .chan_idx (chan_idx)
    );

    evt_route_map #(.NCH(NCH), .ROUTE_W(ROUTE_W), .LINE_A(LINE_A), .LINE_B(LINE_B)) u_route (
        .legacy   (st_q.leg),
        .route_in (chan_route),
        .line_out (chan_line)
    );

    assign wr_cnt_lo  = acc_wr && (reg_sel == RS_CNT_LO);
    assign wr_cnt_hi  = acc_wr && (reg_sel == RS_CNT_HI);
    assign wr_cfg     = acc_wr && (reg_sel == RS_CFG);
    assign wr_cnt_any = wr_cnt_lo || wr_cnt_hi;

    always_comb begin
        st_d = st_q;
        if (wr_cnt_lo) begin
            st_d.cnt[31:0] = acc_wdata;
        end
        if (wr_cnt_hi) begin
            st_d.cnt[63:32] = acc_wdata;
        end
        if (!wr_cnt_any && st_q.en && tick_en) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
        if (wr_cfg) begin
            st_d.en  = acc_wdata[0];
            st_d.leg = acc_wdata[1];
        end
        st_d.arm    = (st_d.en && !st_q.en) ? ~cmp_all_ones : '0;
        st_d.disarm = !st_d.en && st_q.en;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        case (reg_sel)
            RS_CAP_LO: acc_rdata = CAP_LO;
            RS_CAP_HI: acc_rdata = PERIOD_FS;
            RS_CFG:    acc_rdata = {30'd0, st_q.leg, st_q.en};
            RS_CNT_LO: acc_rdata = st_q.cnt[31:0];
            RS_CNT_HI: acc_rdata = st_q.cnt[63:32];
            RS_CHAN:   acc_rdata = chan_rdata[int'(chan_idx)*DATA_W +: DATA_W];
            default:   acc_rdata = '0;
        endcase
    end

    assign chan_reg_off     = acc_addr[WIN_LOG2-1:0];
    assign chan_arm         = st_q.arm;
    assign chan_disarm      = st_q.disarm;
    assign main_count       = st_q.cnt;
    assign count_enabled    = st_q.en;
    assign legacy_timer_off = st_q.leg;

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (count_enabled && tick_en && !wr_cnt_any) |=> (main_count == $past(main_count) + 64'd1)); // R3
    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!count_enabled && !wr_cnt_any) |=> $stable(main_count)); // R3
    AST_CFG_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_cfg |=> (count_enabled == $past(acc_wdata[0]) && legacy_timer_off == $past(acc_wdata[1]))); // R2
    AST_ARM_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        (|chan_arm) |-> $rose(count_enabled)); // R6
    AST_DISARM_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        chan_disarm |-> $fell(count_enabled)); // R5
    AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(chan_sel)); // R9
    AST_LEG_LINE_A: assert property (@(posedge clk) disable iff (!rst_n)
        legacy_timer_off |-> (chan_line[ROUTE_W-1:0] == ROUTE_W'(LINE_A))); // R7
endmodule

// File: tb/evt_timer_core_bench.sv
`timescale 1ns/1ps
module evt_timer_core_bench;
    localparam int NCH = 3;
    localparam int RW  = 5;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             tick_en = 1'b0;
    logic             acc_wr = 1'b0;
    logic [9:0]       acc_addr = '0;
    logic [31:0]      acc_wdata = '0;
    logic [31:0]      acc_rdata;
    logic [95:0]      chan_rdata;
    logic [2:0]       cmp_all_ones = 3'b111;
    logic [14:0]      chan_route = '0;
    logic [2:0]       chan_sel;
    logic [4:0]       chan_reg_off;
    logic [14:0]      chan_line;
    logic [2:0]       chan_arm;
    logic             chan_disarm;
    logic [63:0]      main_count;
    logic             count_enabled;
    logic             legacy_timer_off;

    int  n_chk = 0;
    int  n_fail = 0;
    bit  done = 0;
    logic [31:0] rv;

    always #2 clk = ~clk;

    assign chan_rdata = {32'hC4A5_0002, 32'hC4A5_0001, 32'hC4A5_0000};

    evt_timer_core u_evt_timer_core (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .acc_wr(acc_wr),
        .acc_addr(acc_addr), .acc_wdata(acc_wdata), .acc_rdata(acc_rdata),
        .chan_rdata(chan_rdata), .cmp_all_ones(cmp_all_ones), .chan_route(chan_route),
        .chan_sel(chan_sel), .chan_reg_off(chan_reg_off), .chan_line(chan_line),
        .chan_arm(chan_arm), .chan_disarm(chan_disarm), .main_count(main_count),
        .count_enabled(count_enabled), .legacy_timer_off(legacy_timer_off)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [9:0] a, input logic [31:0] d, input bit t);
        @(negedge clk);
        acc_addr = a; acc_wdata = d; acc_wr = 1'b1; tick_en = t;
        @(posedge clk); #1;
        acc_wr = 1'b0; tick_en = 1'b0;
    endtask

    task automatic rd(input logic [9:0] a);
        @(negedge clk);
        acc_addr = a;
        #1 rv = acc_rdata;
    endtask

    task automatic ticks(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk); tick_en = 1'b1;
            @(posedge clk); #1; tick_en = 1'b0;
        end
    endtask

    task automatic rd_cnt(output logic [63:0] c);
        logic [31:0] lo;
        rd(10'h0F0); lo = rv;
        rd(10'h0F4); c = {rv, lo};
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        #800000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            summary();
            $finish;
        end
    end

    initial begin
        logic [63:0] c;
        repeat (3) @(posedge clk);
        #1;
        // R11 reset state
        chk("R11 count", main_count, 64'd0);
        chk("R11 enable", {63'd0, count_enabled}, 64'd0);
        chk("R11 arm", {61'd0, chan_arm}, 64'd0);
        chk("R11 disarm", {63'd0, chan_disarm}, 64'd0);
        chk("R11 legacy", {63'd0, legacy_timer_off}, 64'd0);
        rst_n = 1'b1;
        rd(10'h010); chk("R11 cfg read", {32'd0, rv}, 64'd0);

        // R1 capability
        rd(10'h000); chk("R1 cap lo", {32'd0, rv}, 64'h8086A201);
        rd(10'h004); chk("R1 period", {32'd0, rv}, 64'd10000000);
        wr(10'h000, 32'h0, 1'b0); wr(10'h004, 32'h0, 1'b0);
        rd(10'h000); chk("R1 cap lo after write", {32'd0, rv}, 64'h8086A201);
        rd(10'h004); chk("R1 period after write", {32'd0, rv}, 64'd10000000);

        // R2 configuration sweep with junk upper bits
        for (int v = 0; v < 4; v++) begin
            wr(10'h010, 32'hFFFF_FFFC | 32'(v), 1'b0);
            rd(10'h010); chk("R2 cfg read", {32'd0, rv}, 64'(v));
            rd(10'h014); chk("R2 cfg high zero", {32'd0, rv}, 64'd0);
        end
        wr(10'h010, 32'h0, 1'b0);

        // R4 counter halves while disabled
        wr(10'h0F0, 32'hFFFF_FFFE, 1'b0);
        wr(10'h0F4, 32'h1234_5678, 1'b0);
        rd_cnt(c); chk("R4 halves", c, 64'h12345678_FFFFFFFE);
        wr(10'h0F4, 32'h1234_5677, 1'b0);
        rd_cnt(c); chk("R4 high only", c, 64'h12345677_FFFFFFFE);
        wr(10'h0F4, 32'h1234_5678, 1'b0);

        // R3 frozen while disabled
        ticks(4);
        chk("R3 hold disabled", main_count, 64'h12345678_FFFFFFFE);

        // R3 counting with carry; tick on the enable write is not counted
        wr(10'h010, 32'h1, 1'b1);
        chk("R3 enable-write tick ignored", main_count, 64'h12345678_FFFFFFFE);
        ticks(3);
        chk("R3 carry", main_count, 64'h12345679_00000001);
        repeat (5) @(posedge clk);
        #1 chk("R3 no tick no change", main_count, 64'h12345679_00000001);
        ticks(10);
        chk("R3 ten ticks", main_count, 64'h12345679_0000000B);

        // R4 write and tick in the same cycle
        wr(10'h0F0, 32'h0000_AAAA, 1'b1);
        chk("R4 write beats tick", main_count, 64'h12345679_0000AAAA);
        wr(10'h0F4, 32'h0000_0003, 1'b1);
        chk("R4 high write beats tick", main_count, 64'h00000003_0000AAAA);

        // R5 disable: one-cycle disarm, counter frozen
        wr(10'h010, 32'h0, 1'b1);
        chk("R5 disarm pulse", {63'd0, chan_disarm}, 64'd1);
        chk("R5 tick on disable write counted", main_count, 64'h00000003_0000AAAB);
        @(posedge clk); #1;
        chk("R5 disarm single", {63'd0, chan_disarm}, 64'd0);
        ticks(6);
        chk("R5 frozen", main_count, 64'h00000003_0000AAAB);

        // R6 arm mask sweep
        for (int m = 0; m < 8; m++) begin
            cmp_all_ones = 3'(m);
            wr(10'h010, 32'h1, 1'b0);
            chk("R6 arm mask", {61'd0, chan_arm}, {61'd0, ~3'(m)});
            chk("R6 no disarm", {63'd0, chan_disarm}, 64'd0);
            @(posedge clk); #1;
            chk("R6 arm single", {61'd0, chan_arm}, 64'd0);
            wr(10'h010, 32'h0, 1'b0);
        end
        cmp_all_ones = 3'b111;
        wr(10'h010, 32'h1, 1'b0);
        ticks(2);
        chk("R6 resume", main_count, 64'h00000003_0000AAAD);
        wr(10'h010, 32'h1, 1'b0);
        chk("R6 no rearm when already on", {61'd0, chan_arm}, 64'd0);

        // R7 routing sweep, R8 legacy output
        for (int lg = 0; lg < 2; lg++) begin
            wr(10'h010, 32'(lg << 1), 1'b0);
            chk("R8 legacy output", {63'd0, legacy_timer_off}, 64'(lg));
            for (int r = 0; r < 32; r++) begin
                logic [4:0] r0, r1, r2;
                r0 = 5'(r); r1 = 5'(r + 7); r2 = 5'(r + 13);
                @(negedge clk);
                chan_route = {r2, r1, r0};
                #1;
                chk("R7 line0", {59'd0, chan_line[4:0]}, {59'd0, (lg != 0) ? 5'd0 : r0});
                chk("R7 line1", {59'd0, chan_line[9:5]}, {59'd0, (lg != 0) ? 5'd8 : r1});
                chk("R7 line2", {59'd0, chan_line[14:10]}, {59'd0, r2});
            end
        end
        wr(10'h010, 32'h0, 1'b0);
        chk("R8 legacy cleared", {63'd0, legacy_timer_off}, 64'd0);

        // R9 channel window sweep
        for (int a = 'h100; a < 'h400; a += 4) begin
            int idx;
            logic [2:0]  es;
            logic [31:0] ed;
            idx = (a - 'h100) / 32;
            es = (idx < NCH) ? 3'(1 << idx) : 3'd0;
            ed = (idx < NCH) ? (32'hC4A5_0000 + 32'(idx)) : 32'd0;
            rd(10'(a));
            chk("R9 sel", {61'd0, chan_sel}, {61'd0, es});
            chk("R9 rdata", {32'd0, rv}, {32'd0, ed});
            if (idx < NCH) chk("R9 offset", {59'd0, chan_reg_off}, 64'(a % 32));
        end
        rd(10'h0F0);
        chk("R9 no sel outside window", {61'd0, chan_sel}, 64'd0);

        // R10 status and undecoded offsets
        wr(10'h020, 32'hFFFF_FFFF, 1'b0);
        wr(10'h0F8, 32'hFFFF_FFFF, 1'b0);
        wr(10'h3FC, 32'hFFFF_FFFF, 1'b0);
        rd(10'h020); chk("R10 status zero", {32'd0, rv}, 64'd0);
        rd(10'h008); chk("R10 undecoded 008", {32'd0, rv}, 64'd0);
        rd(10'h0F8); chk("R10 undecoded 0F8", {32'd0, rv}, 64'd0);
        rd(10'h018); chk("R10 undecoded 018", {32'd0, rv}, 64'd0);
        rd(10'h010); chk("R10 cfg untouched", {32'd0, rv}, 64'd0);
        chk("R10 count untouched", main_count, 64'h00000003_0000AAAD);

        // R8 and R11: reset clears legacy request and state
        wr(10'h010, 32'h3, 1'b0);
        chk("R8 legacy set", {63'd0, legacy_timer_off}, 64'd1);
        @(negedge clk); rst_n = 1'b0;
        @(posedge clk); #1;
        chk("R8 reset releases", {63'd0, legacy_timer_off}, 64'd0);
        chk("R11 reset count", main_count, 64'd0);
        chk("R11 reset enable", {63'd0, count_enabled}, 64'd0);
        rst_n = 1'b1;

        done = 1;
        summary();
        $finish;
    end
endmodule